// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Engine

This block is the arithmetic core of a multiply-accumulate unit. Each accepted command either forms the product of two 32-bit operands and adds it to, or subtracts it from, one of four accumulators, or performs a housekeeping action on an accumulator: saturate, clear, copy, or clear the overflow flag. The product can be treated as a signed integer, an unsigned integer or a signed fraction. Overflow handling depends on the mode. Fractional products can be rounded to nearest with ties to even. The product can also be shifted by one bit before it is accumulated.

Each accumulator holds a 48-bit result plus 16 guard bits, so it is stored as 64 bits and the guard bits can record an overflow until a saturate command resolves it. When the overflow-mode input is high, an overflowing product is replaced by a large marker value (2^50, or its bitwise inverse for negative products). This makes the following accumulation overflow in a way that saturation will catch. A sticky overflow flag and one sticky per-accumulator overflow bit form the status. Every command completes in the clock edge that accepts it, and the status changes on that same edge as the accumulator it concerns.

Top module: `mac_sat_engine`

## Requirements
- R1: After reset, all four accumulators are zero, the overflow flag `v_flag` is low and `pav` is 4'b0000.
- R2: In signed integer mode (`cmd_mode` 0, or 3), the 64-bit signed product overflows when sign-extending it from bit 39 changes it. An overflow sets `v_flag`. Without `omc`, the product used is the sign-extended low 40 bits.
- R3: A signed overflow with `omc` high replaces the product by 2^50 when the product is non-negative, and by the bitwise inverse of 2^50 when it is negative.
- R4: In unsigned mode (`cmd_mode` 1), the product overflows when any of bits 63..40 is set, and the overflow sets `v_flag`. The replacement product is 2^50 with `omc` high, and the low 40 bits otherwise.
- R5: In fractional mode (`cmd_mode` 2), the signed product is shifted right arithmetically by 24. With `rnd` high, a discarded part above 0x800000 adds one. A discarded part of exactly 0x800000 adds one only when the shifted value is odd.
- R6: `cmd_shift` 1 shifts the product left by one bit and `cmd_shift` 2 shifts it right arithmetically by one bit, before it is accumulated. Values 0 and 3 leave it unchanged.
- R7: `cmd_op` 0 adds the product to accumulator `cmd_dst` and `cmd_op` 1 subtracts it, with 64-bit wrap. The result and any change to `v_flag` appear together after the accepting edge.
- R8: Saturate (`cmd_op` 2) in signed integer mode flags an overflow when the accumulator is not a sign-extended 48-bit value, and then sets `v_flag`. The accumulator becomes its 48-bit sign extension. If `v_flag` is high after this check, `pav[cmd_dst]` is set. With `omc` high it is also clamped to 0x7FFFFFFF, or to the inverse of that value when bit 47 is set.
- R9: Saturate in fractional mode uses the same check, but clamps to 0x7FFFFFFFFFFF or its inverse.
- R10: Saturate in unsigned mode flags an overflow when bits 63..48 are nonzero. When `v_flag` is high after the check, it sets `pav[cmd_dst]`. The accumulator then becomes 0 if it exceeds 2^53 and 2^48-1 otherwise (with `omc` high), or is masked to 48 bits (with `omc` low).
- R11: Clear (`cmd_op` 3) zeroes accumulator `cmd_dst` and clears `pav[cmd_dst]`. Move (`cmd_op` 4) copies accumulator `cmd_src` and its `pav` bit into `cmd_dst`.
- R12: `cmd_op` 5 clears `v_flag`, which otherwise stays set once raised. Codes 6 and 7 have no effect, and so does any command presented while `cmd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe; a command is taken on each edge where this is high |
| cmd_op | input | 3 | 0 add, 1 subtract, 2 saturate, 3 clear, 4 move, 5 clear flag |
| cmd_mode | input | 2 | 0 signed integer, 1 unsigned, 2 fractional, 3 as signed |
| cmd_shift | input | 2 | 0 none, 1 left by one, 2 right by one, 3 none |
| cmd_dst | input | 2 | Target accumulator index |
| cmd_src | input | 2 | Source accumulator index for move |
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand |
| omc | input | 1 | Overflow mode: sentinel products and clamping saturation |
| rnd | input | 1 | Round fractional products to nearest, ties to even |
| acc_flat | output | 256 | Four 64-bit accumulators; index i at bits 64*i+63..64*i |
| v_flag | output | 1 | Sticky overflow flag |
| pav | output | 4 | Sticky per-accumulator overflow bits, bit i for accumulator i |

## Verification
Some clamping branches are only reached when the guard bits already hold an overflow or a stale `v_flag`. The hardest of these is the unsigned branch that returns zero for an accumulator above 2^53. The stimulus reaches it by subtracting a 2^50 sentinel from a cleared accumulator, which leaves all the high bits set. It also saturates small values while `v_flag` is still set from an earlier product overflow, to cover clamping without a fresh overflow. A long run of random commands, compared each clock against a behavioural model, then mixes every mode and shift with moves and flag clears.

// File: rtl/mac_pkg.sv
package mac_pkg;
    typedef enum logic [2:0] {
        CMD_MAC_ADD = 3'd0,
        CMD_MAC_SUB = 3'd1,
        CMD_SAT     = 3'd2,
        CMD_CLEAR   = 3'd3,
        CMD_MOVE    = 3'd4,
        CMD_CLRV    = 3'd5
    } mac_cmd_e;

    typedef enum logic [1:0] {
        MODE_SINT = 2'd0,
        MODE_UINT = 2'd1,
        MODE_FRAC = 2'd2,
        MODE_RSVD = 2'd3
    } mac_mode_e;

    typedef enum logic [1:0] {
        SH_NONE  = 2'd0,
        SH_LEFT  = 2'd1,
        SH_RIGHT = 2'd2,
        SH_RSVD  = 2'd3
    } mac_shift_e;
endpackage

// File: rtl/mac_product.sv
module mac_product
    import mac_pkg::*;
#(
    parameter int OPW     = 32,
    parameter int PRODW   = 40,
    parameter int FRACSH  = 24,
    parameter int SENTBIT = 50
) (
    input  logic [OPW-1:0]   a,
    input  logic [OPW-1:0]   b,
    input  mac_mode_e        mode,
    input  mac_shift_e       shift,
    input  logic             omc,
    input  logic             rnd,
    output logic [2*OPW-1:0] prod,
    output logic             ovf
);
    localparam int W = 2 * OPW;
    localparam logic [W-1:0]      SENT = W'(1) << SENTBIT;
    localparam logic [FRACSH-1:0] HALF = FRACSH'(1) << (FRACSH - 1);

    logic signed [W-1:0] sprod;
    logic        [W-1:0] uprod;
    logic signed [W-1:0] s_trunc;
    logic signed [W-1:0] frac_q;
    logic [FRACSH-1:0]   frac_rem;
    logic        [W-1:0] base;

    always_comb begin
        sprod    = $signed({{OPW{a[OPW-1]}}, a}) * $signed({{OPW{b[OPW-1]}}, b});
        uprod    = {{OPW{1'b0}}, a} * {{OPW{1'b0}}, b};
        s_trunc  = {{(W-PRODW){sprod[PRODW-1]}}, sprod[PRODW-1:0]};
        frac_q   = sprod >>> FRACSH;
        frac_rem = sprod[FRACSH-1:0];
        ovf      = 1'b0;
        base     = s_trunc;
        unique case (mode)
            MODE_UINT: begin
                if (|uprod[W-1:PRODW]) begin
                    ovf  = 1'b1;
                    base = omc ? SENT : {{(W-PRODW){1'b0}}, uprod[PRODW-1:0]};
                end else begin
                    base = uprod;
                end
            end
            MODE_FRAC: begin
                base = frac_q;
                if (rnd) begin
                    if (frac_rem > HALF)
                        base = frac_q + W'(1);
                    else if (frac_rem == HALF)
                        base = frac_q + {{(W-1){1'b0}}, frac_q[0]};
                end
            end
            MODE_SINT, MODE_RSVD: begin
                ovf = (s_trunc != sprod);
                if (ovf && omc)
                    base = sprod[W-1] ? ~SENT : SENT;
                else
                    base = s_trunc;
            end
            default: base = s_trunc;
        endcase
        unique case (shift)
            SH_LEFT:  prod = base << 1;
            SH_RIGHT: prod = W'($signed(base) >>> 1);
            default:  prod = base;
        endcase
    end
endmodule

// File: rtl/mac_saturate.sv
module mac_saturate
    import mac_pkg::*;
#(
    parameter int OPW     = 32,
    parameter int SATW    = 48,
    parameter int WRAPBIT = 53
) (
    input  logic [2*OPW-1:0] acc,
    input  mac_mode_e        mode,
    input  logic             omc,
    input  logic             v_in,
    output logic [2*OPW-1:0] res,
    output logic             ovf,
    output logic             mark
);
    localparam int W = 2 * OPW;
    localparam logic [W-1:0] SMAX_I = {{(W-OPW+1){1'b0}}, {(OPW-1){1'b1}}};
    localparam logic [W-1:0] SMAX_F = {{(W-SATW+1){1'b0}}, {(SATW-1){1'b1}}};
    localparam logic [W-1:0] UMAX   = {{(W-SATW){1'b0}}, {SATW{1'b1}}};
    localparam logic [W-1:0] UBIG   = W'(1) << WRAPBIT;

    logic [W-1:0] sext;

    always_comb begin
        sext = {{(W-SATW){acc[SATW-1]}}, acc[SATW-1:0]};
        if (mode == MODE_UINT) begin
            ovf  = |acc[W-1:SATW];
            mark = v_in | ovf;
            res  = acc;
            if (mark)
                res = omc ? ((acc > UBIG) ? '0 : UMAX) : (acc & UMAX);
        end else begin
            ovf  = (sext != acc);
            mark = v_in | ovf;
            res  = sext;
            if (mark && omc) begin
                if (mode == MODE_FRAC)
                    res = sext[W-1] ? ~SMAX_F : SMAX_F;
                else
                    res = sext[W-1] ? ~SMAX_I : SMAX_I;
            end
        end
    end
endmodule

// File: rtl/mac_sat_engine.sv
module mac_sat_engine
    import mac_pkg::*;
#(
    parameter int NACC    = 4,
    parameter int OPW     = 32,
    parameter int SATW    = 48,
    parameter int PRODW   = 40,
    parameter int FRACSH  = 24,
    parameter int SENTBIT = 50,
    parameter int WRAPBIT = 53
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_valid,
    input  logic [2:0]                 cmd_op,
    input  logic [1:0]                 cmd_mode,
    input  logic [1:0]                 cmd_shift,
    input  logic [$clog2(NACC)-1:0]    cmd_dst,
    input  logic [$clog2(NACC)-1:0]    cmd_src,
    input  logic [OPW-1:0]             op_a,
    input  logic [OPW-1:0]             op_b,
    input  logic                       omc,
    input  logic                       rnd,
    output logic [NACC*2*OPW-1:0]      acc_flat,
    output logic                       v_flag,
    output logic [NACC-1:0]            pav
);
    localparam int W = 2 * OPW;

    mac_cmd_e   op_e;
    mac_mode_e  mode_e;
    mac_shift_e shift_e;

    logic [W-1:0]    acc_q [NACC];
    logic            v_q;
    logic [NACC-1:0] pav_q;

    logic [W-1:0] prod;
    logic         prod_ovf;
    logic [W-1:0] sat_res;
    logic         sat_ovf;
    logic         sat_mark;

    always_comb begin
        op_e    = mac_cmd_e'(cmd_op);
        mode_e  = mac_mode_e'(cmd_mode);
        shift_e = mac_shift_e'(cmd_shift);
    end

    mac_product #(
        .OPW(OPW), .PRODW(PRODW), .FRACSH(FRACSH), .SENTBIT(SENTBIT)
    ) u_prod (
        .a(op_a), .b(op_b), .mode(mode_e), .shift(shift_e),
        .omc(omc), .rnd(rnd), .prod(prod), .ovf(prod_ovf)
    );

    mac_saturate #(
        .OPW(OPW), .SATW(SATW), .WRAPBIT(WRAPBIT)
    ) u_sat (
        .acc(acc_q[cmd_dst]), .mode(mode_e), .omc(omc), .v_in(v_q),
        .res(sat_res), .ovf(sat_ovf), .mark(sat_mark)
    );

    // Accumulator bank and status register, one process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NACC; i++) acc_q[i] <= '0;
            v_q   <= 1'b0;
            pav_q <= '0;
        end else if (cmd_valid) begin
            case (op_e)
                CMD_MAC_ADD: begin
                    acc_q[cmd_dst] <= acc_q[cmd_dst] + prod;
                    if (prod_ovf) v_q <= 1'b1;
                end
                CMD_MAC_SUB: begin
                    acc_q[cmd_dst] <= acc_q[cmd_dst] - prod;
                    if (prod_ovf) v_q <= 1'b1;
                end
                CMD_SAT: begin
                    acc_q[cmd_dst] <= sat_res;
                    if (sat_ovf)  v_q <= 1'b1;
                    if (sat_mark) pav_q[cmd_dst] <= 1'b1;
                end
                CMD_CLEAR: begin
                    acc_q[cmd_dst] <= '0;
                    pav_q[cmd_dst] <= 1'b0;
                end
                CMD_MOVE: begin
                    acc_q[cmd_dst] <= acc_q[cmd_src];
                    pav_q[cmd_dst] <= pav_q[cmd_src];
                end
                CMD_CLRV: v_q <= 1'b0;
                default: ;
            endcase
        end
    end

    generate
        for (genvar g = 0; g < NACC; g++) begin : g_flat
            assign acc_flat[g*W +: W] = acc_q[g];
        end
    endgenerate

    assign v_flag = v_q;
    assign pav    = pav_q;

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(acc_flat) && $stable(v_q) && $stable(pav_q)));

    // R11
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'd3) |=>
            (acc_q[$past(cmd_dst)] == '0 && !pav_q[$past(cmd_dst)]));

    // R12
    v_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(v_q) |-> $past(cmd_valid && cmd_op == 3'd5));

    // R8
    pav_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pav_q & ~$past(pav_q))) |-> $past(cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd4)));

    // R2
    v_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(v_q) |-> $past(cmd_valid && cmd_op <= 3'd2));
endmodule

// File: tb/test_mac_sat_engine.sv
`timescale 1ns/1ps
module test_mac_sat_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_op = '0;
    logic [1:0]   cmd_mode = '0;
    logic [1:0]   cmd_shift = '0;
    logic [1:0]   cmd_dst = '0;
    logic [1:0]   cmd_src = '0;
    logic [31:0]  op_a = '0;
    logic [31:0]  op_b = '0;
    logic         omc = 1'b0;
    logic         rnd = 1'b0;
    logic [255:0] acc_flat;
    logic         v_flag;
    logic [3:0]   pav;

    int compared = 0;
    int mismatched = 0;
    string cur_req = "R1";

    longint  m_acc [4];
    bit      m_v;
    bit [3:0] m_pav;

    always #4 clk = ~clk;

    mac_sat_engine i_mac_sat_engine (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mode(cmd_mode), .cmd_shift(cmd_shift), .cmd_dst(cmd_dst),
        .cmd_src(cmd_src), .op_a(op_a), .op_b(op_b), .omc(omc), .rnd(rnd),
        .acc_flat(acc_flat), .v_flag(v_flag), .pav(pav)
    );

    // Behavioural product (R2..R6)
    function automatic longint mprod(int mode, int sh, bit [31:0] a, bit [31:0] b,
                                     bit om, bit rn, output bit ov);
        longint p, q, t, rem;
        longint unsigned u;
        ov = 0;
        if (mode == 1) begin
            u = longint'(a) * longint'(b);
            if ((u >> 40) != 0) begin
                ov = 1;
                u = om ? (64'd1 << 50) : (u & ((64'd1 << 40) - 1));
            end
            p = longint'(u);
        end else if (mode == 2) begin
            p = longint'($signed(a)) * longint'($signed(b));
            q = p >>> 24;
            rem = p & 64'hFF_FFFF;
            if (rn) begin
                if (rem > 64'h80_0000) q = q + 1;
                else if (rem == 64'h80_0000) q = q + (q & 1);
            end
            p = q;
        end else begin
            p = longint'($signed(a)) * longint'($signed(b));
            t = (p <<< 24) >>> 24;
            if (t != p) begin
                ov = 1;
                if (om) p = (p < 0) ? ~(64'sd1 <<< 50) : (64'sd1 <<< 50);
                else p = t;
            end
        end
        if (sh == 1) p = p <<< 1;
        else if (sh == 2) p = p >>> 1;
        return p;
    endfunction

    // Behavioural saturation (R8..R10)
    function automatic longint msat(int mode, longint acc, bit om, bit vin,
                                    output bit ov, output bit mk);
        longint t;
        longint unsigned ua;
        ua = longint'(acc);
        if (mode == 1) begin
            ov = ((ua >> 48) != 0);
            mk = vin | ov;
            t = acc;
            if (mk) begin
                if (om) t = (ua > (64'd1 << 53)) ? 0 : longint'((64'd1 << 48) - 1);
                else t = longint'(ua & ((64'd1 << 48) - 1));
            end
        end else begin
            t = (acc <<< 16) >>> 16;
            ov = (t != acc);
            mk = vin | ov;
            if (mk && om) begin
                if (mode == 2) t = (t < 0) ? ~longint'(64'h7FFF_FFFF_FFFF) : longint'(64'h7FFF_FFFF_FFFF);
                else t = (t < 0) ? ~longint'(64'h7FFF_FFFF) : longint'(64'h7FFF_FFFF);
            end
        end
        return t;
    endfunction

    task automatic compare_all();
        bit bad = 0;
        compared++;
        for (int i = 0; i < 4; i++) begin
            if (acc_flat[i*64 +: 64] !== 64'(m_acc[i])) begin
                bad = 1;
                $display("FAIL %s acc%0d actual=%h expected=%h", cur_req, i,
                         acc_flat[i*64 +: 64], 64'(m_acc[i]));
            end
        end
        if (v_flag !== m_v) begin
            bad = 1;
            $display("FAIL %s v_flag actual=%b expected=%b", cur_req, v_flag, m_v);
        end
        if (pav !== m_pav) begin
            bad = 1;
            $display("FAIL %s pav actual=%b expected=%b", cur_req, pav, m_pav);
        end
        if (bad) mismatched++;
    endtask

    task automatic cmd(bit vld, int op, int mode, int sh, int dst, int src,
                       bit [31:0] a, bit [31:0] b, bit om, bit rn);
        bit ov, mk;
        longint p, r;
        cmd_valid = vld; cmd_op = 3'(op); cmd_mode = 2'(mode); cmd_shift = 2'(sh);
        cmd_dst = 2'(dst); cmd_src = 2'(src); op_a = a; op_b = b; omc = om; rnd = rn;
        if (vld) begin
            case (op)
                0, 1: begin
                    p = mprod(mode, sh, a, b, om, rn, ov);
                    m_acc[dst] = (op == 0) ? m_acc[dst] + p : m_acc[dst] - p;
                    if (ov) m_v = 1;
                end
                2: begin
                    r = msat(mode, m_acc[dst], om, m_v, ov, mk);
                    m_acc[dst] = r;
                    if (ov) m_v = 1;
                    if (mk) m_pav[dst] = 1;
                end
                3: begin m_acc[dst] = 0; m_pav[dst] = 0; end
                4: begin m_acc[dst] = m_acc[src]; m_pav[dst] = m_pav[src]; end
                5: m_v = 0;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0;
        compare_all();
    endtask

    initial begin
        #(8 * 200000);
        $display("FAIL watchdog expired actual=running expected=finished");
        mismatched++;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_acc[i] = 0;
        m_v = 0; m_pav = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1"; compare_all();

        cur_req = "R7";
        cmd(1, 0, 0, 0, 0, 0, 3, 4, 0, 0);
        cmd(1, 1, 0, 0, 0, 0, 5, 32'hFFFF_FFFE, 0, 0);
        cmd(1, 0, 1, 0, 1, 0, 32'h0001_0000, 32'h0001_0000, 0, 0);
        cmd(1, 1, 3, 0, 2, 0, 7, 9, 0, 0);

        cur_req = "R2";
        cmd(1, 0, 0, 0, 3, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0);
        cur_req = "R12"; cmd(1, 5, 0, 0, 0, 0, 0, 0, 0, 0);
        cmd(0, 3, 0, 0, 0, 0, 0, 0, 0, 0);
        cmd(1, 6, 0, 0, 0, 0, 0, 0, 0, 0);
        cmd(1, 7, 0, 0, 1, 0, 0, 0, 0, 0);

        cur_req = "R3";
        cmd(1, 3, 0, 0, 0, 0, 0, 0, 0, 0);
        cmd(1, 0, 0, 0, 0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 0);
        cmd(1, 3, 0, 0, 1, 0, 0, 0, 0, 0);
        cmd(1, 0, 0, 0, 1, 0, 32'h8000_0000, 32'h7FFF_FFFF, 1, 0);

        cur_req = "R8";
        cmd(1, 2, 0, 0, 0, 0, 0, 0, 1, 0);
        cmd(1, 2, 0, 0, 1, 0, 0, 0, 1, 0);
        cmd(1, 5, 0, 0, 0, 0, 0, 0, 0, 0);
        cmd(1, 3, 0, 0, 2, 0, 0, 0, 0, 0);
        cmd(1, 0, 0, 0, 2, 0, 100, 100, 0, 0);
        cmd(1, 2, 0, 0, 2, 0, 0, 0, 1, 0);

        cur_req = "R4";
        cmd(1, 3, 0, 0, 0, 0, 0, 0, 0, 0);
        cmd(1, 0, 1, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
        cmd(1, 3, 0, 0, 0, 0, 0, 0, 0, 0);
        cmd(1, 0, 1, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0);
        cmd(1, 5, 0, 0, 0, 0, 0, 0, 0, 0);
        cmd(1, 0, 1, 0, 0, 0, 32'h00FF_FFFF, 32'h0000_FFFF, 0, 0);

        cur_req = "R10";
        cmd(1, 2, 1, 0, 0, 0, 0, 0, 1, 0);
        cmd(1, 3, 0, 0, 3, 0, 0, 0, 0, 0);
        cmd(1, 1, 1, 0, 3, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0);
        cmd(1, 2, 1, 0, 3, 0, 0, 0, 1, 0);
        cmd(1, 3, 0, 0, 3, 0, 0, 0, 0, 0);
        cmd(1, 0, 1, 0, 3, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0);
        cmd(1, 0, 0, 1, 3, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 0);
        cmd(1, 2, 1, 0, 3, 0, 0, 0, 0, 0);

        cur_req = "R5";
        cmd(1, 5, 0, 0, 0, 0, 0, 0, 0, 0);
        cmd(1, 3, 0, 0, 0, 0, 0, 0, 0, 0);
        cmd(1, 0, 2, 0, 0, 0, 32'h0080_0000, 1, 0, 1);
        cmd(1, 0, 2, 0, 0, 0, 32'h0080_0000, 3, 0, 1);
        cmd(1, 0, 2, 0, 0, 0, 32'h00C0_0000, 1, 0, 1);
        cmd(1, 0, 2, 0, 0, 0, 32'h00C0_0000, 1, 0, 0);
        cmd(1, 0, 2, 0, 0, 0, 32'h4000_0000, 32'h4000_0000, 0, 0);
        cmd(1, 1, 2, 0, 0, 0, 32'hFF40_0000, 1, 0, 1);

        cur_req = "R6";
        cmd(1, 3, 0, 0, 1, 0, 0, 0, 0, 0);
        cmd(1, 0, 0, 1, 1, 0, 1000, 3, 0, 0);
        cmd(1, 0, 0, 2, 1, 0, 32'hFFFF_FFF9, 1, 0, 0);
        cmd(1, 0, 0, 3, 1, 0, 11, 1, 0, 0);

        cur_req = "R9";
        cmd(1, 3, 0, 0, 2, 0, 0, 0, 0, 0);
        cmd(1, 0, 0, 0, 2, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 0);
        cmd(1, 2, 2, 0, 2, 0, 0, 0, 1, 0);
        cmd(1, 1, 0, 0, 2, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 0);
        cmd(1, 1, 0, 0, 2, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1, 0);
        cmd(1, 2, 2, 0, 2, 0, 0, 0, 1, 0);

        cur_req = "R11";
        cmd(1, 4, 0, 0, 0, 2, 0, 0, 0, 0);
        cmd(1, 4, 0, 0, 3, 1, 0, 0, 0, 0);
        cmd(1, 3, 0, 0, 2, 0, 0, 0, 0, 0);

        cur_req = "R7";
        for (int n = 0; n < 400; n++) begin
            cmd($urandom_range(0, 7) != 0, $urandom_range(0, 7), $urandom_range(0, 3),
                $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
                $urandom(), ($urandom_range(0, 1) != 0) ? $urandom() : 32'($urandom_range(0, 255)),
                $urandom_range(0, 1) != 0, $urandom_range(0, 1) != 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule